// File: doc/BRIEF.md
# Extended Negate ALU Unit

This unit forms the two's-complement negation of an operand with the extend bit folded in as a borrow: the result is zero minus the operand, minus one more when the incoming extend flag is set. It works at one of three operand sizes. At each size only the low lanes of the operand enter the sign and zero tests, and only those lanes are replaced in the returned value. The upper bits of the operand pass through unchanged, so the output can be written straight back to a full-width data register.

Multi-precision negation is done by running the unit once per word, least significant word first. The extend and zero outputs of one step are fed back as the inputs of the next. The zero flag never gets set by this operation; it can only be cleared. So after the whole chain it reads one only if every partial result was zero, provided it was set to one before the first step. The result and all five flags are captured on the clock edge at which the start strobe is high, and a one-cycle done pulse follows.

Top module: `negx_unit`

## Requirements
- R1: The low S bits of the result equal (0 - operand - x_in) modulo 2^S, where S is the selected size in bits.
- R2: Size code 0 selects one lane (LANE_W bits), code 1 selects two lanes, code 2 selects four lanes (full width), and code 3 acts like code 2. Sign and zero tests look only at the bits of the selected size.
- R3: v_out is 1 exactly when the operand's sign bit and the result's sign bit, both taken at the selected size, are 1.
- R4: c_out and x_out both equal the operand sign bit OR the result sign bit, at the selected size.
- R5: z_out equals z_in AND (the size-masked result is zero). A nonzero result clears it, and a zero result keeps the incoming value.
- R6: n_out is the sign bit of the result at the selected size.
- R7: Result bits above the selected size are copied unchanged from the operand.
- R8: Result and flags change on the clock edge at which start is high, and done is high for exactly the following cycle of each start.
- R9: While start is low, the result and flags hold their values whatever the other inputs do.
- R10: Synchronous active-high reset clears the result, all five flags and done to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture a new operation on this edge |
| size | input | 2 | Operand size code (0 one lane, 1 two lanes, 2 or 3 four lanes) |
| operand | input | 4*LANE_W | Value to negate; upper bits pass through |
| x_in | input | 1 | Incoming extend flag (borrow) |
| z_in | input | 1 | Incoming zero flag |
| result | output | 4*LANE_W | Negated low lanes merged with operand upper lanes |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag (sticky) |
| v_out | output | 1 | New overflow flag |
| c_out | output | 1 | New carry flag |
| done | output | 1 | One-cycle pulse after each start |

## Verification
The bench builds the unit with LANE_W = 4, which gives 4-bit, 8-bit and 16-bit sizes. At that width every operand of the two smaller sizes can be tried under all four combinations of incoming extend and zero. That covers every sign, overflow and zero corner, including the most negative value and zero with and without borrow. The full size is swept with a coarse stride plus its extreme values, and the reserved size code is compared against it. Back-to-back starts, idle hold and a mid-run reset exercise the timing.

// File: rtl/negx_pkg.sv
`timescale 1ns/1ps
package negx_pkg;

    localparam int unsigned NEGX_LANES = 4;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'd0,
        SZ_TWO  = 2'd1,
        SZ_FOUR = 2'd2,
        SZ_ALT  = 2'd3
    } negx_size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } negx_ccr_t;

    // thermometer of active lanes for a size code
    function automatic logic [NEGX_LANES-1:0] lane_enable(negx_size_e s);
        case (s)
            SZ_ONE:  lane_enable = 4'b0001;
            SZ_TWO:  lane_enable = 4'b0011;
            default: lane_enable = 4'b1111;
        endcase
    endfunction

    // pick the sign bit belonging to the selected size
    function automatic logic pick_sign(negx_size_e s, logic s1, logic s2, logic s4);
        case (s)
            SZ_ONE:  pick_sign = s1;
            SZ_TWO:  pick_sign = s2;
            default: pick_sign = s4;
        endcase
    endfunction

endpackage

// File: rtl/negx_lane_mask.sv
`timescale 1ns/1ps
module negx_lane_mask
    import negx_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW = LANE_W * NEGX_LANES
) (
    input  negx_size_e      size,
    output logic [DW-1:0]   mask
);
    logic [NEGX_LANES-1:0] lane_on;

    assign lane_on = lane_enable(size);

    for (genvar g = 0; g < NEGX_LANES; g++) begin : g_lane
        assign mask[g*LANE_W +: LANE_W] = {LANE_W{lane_on[g]}};
    end
endmodule

// File: rtl/negx_core.sv
`timescale 1ns/1ps
module negx_core
    import negx_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW = LANE_W * NEGX_LANES
) (
    input  logic [DW-1:0]   operand,
    input  negx_size_e      size,
    input  logic            x_in,
    input  logic            z_in,
    input  logic [DW-1:0]   mask,
    output logic [DW-1:0]   result,
    output negx_ccr_t       ccr
);
    logic [DW-1:0] diff;
    logic [DW-1:0] low_part;
    logic          op_sign;
    logic          res_sign;

    // the low bits of a full-width subtraction equal the sized subtraction
    assign diff     = '0 - operand - {{(DW-1){1'b0}}, x_in};
    assign low_part = diff & mask;
    assign result   = low_part | (operand & ~mask);

    assign op_sign  = pick_sign(size, operand[LANE_W-1], operand[2*LANE_W-1], operand[DW-1]);
    assign res_sign = pick_sign(size, diff[LANE_W-1], diff[2*LANE_W-1], diff[DW-1]);

    always_comb begin
        ccr.n = res_sign;
        ccr.v = op_sign & res_sign;
        ccr.c = op_sign | res_sign;
        ccr.x = op_sign | res_sign;
        ccr.z = z_in & (low_part == '0);
    end
endmodule

// File: rtl/negx_regs.sv
`timescale 1ns/1ps
module negx_regs
    import negx_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [DW-1:0]   nxt_result,
    input  negx_ccr_t       nxt_ccr,
    output logic [DW-1:0]   result_q,
    output negx_ccr_t       ccr_q,
    output logic            done_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ccr_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                result_q <= nxt_result;
                ccr_q    <= nxt_ccr;
            end
        end
    end

    p_done_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> done_q);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done_q);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result_q) && $stable(ccr_q)));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (result_q == '0 && ccr_q == '0 && !done_q));
endmodule

// File: rtl/negx_unit.sv
`timescale 1ns/1ps
module negx_unit
    import negx_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW = LANE_W * NEGX_LANES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      size,
    input  logic [DW-1:0]   operand,
    input  logic            x_in,
    input  logic            z_in,
    output logic [DW-1:0]   result,
    output logic            x_out,
    output logic            n_out,
    output logic            z_out,
    output logic            v_out,
    output logic            c_out,
    output logic            done
);
    negx_size_e     size_e;
    logic [DW-1:0]  mask;
    logic [DW-1:0]  nxt_result;
    negx_ccr_t      nxt_ccr;
    negx_ccr_t      ccr_q;

    assign size_e = negx_size_e'(size);

    negx_lane_mask #(.LANE_W(LANE_W)) u_mask (
        .size (size_e),
        .mask (mask)
    );

    negx_core #(.LANE_W(LANE_W)) u_core (
        .operand (operand),
        .size    (size_e),
        .x_in    (x_in),
        .z_in    (z_in),
        .mask    (mask),
        .result  (nxt_result),
        .ccr     (nxt_ccr)
    );

    negx_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .nxt_result (nxt_result),
        .nxt_ccr    (nxt_ccr),
        .result_q   (result),
        .ccr_q      (ccr_q),
        .done_q     (done)
    );

    assign x_out = ccr_q.x;
    assign n_out = ccr_q.n;
    assign z_out = ccr_q.z;
    assign v_out = ccr_q.v;
    assign c_out = ccr_q.c;

    p_zero_never_set_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !z_in) |=> !z_out);

    p_overflow_needs_sign_r3: assert property (@(posedge clk) disable iff (rst)
        v_out |-> (n_out && c_out));

    p_upper_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && size == 2'd0) |=> (result[DW-1:LANE_W] == $past(operand[DW-1:LANE_W])));

    p_upper_two_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && size == 2'd1) |=> (result[DW-1:2*LANE_W] == $past(operand[DW-1:2*LANE_W])));
endmodule

// File: tb/negx_unit_tb.sv
`timescale 1ns/1ps
module negx_unit_tb_top;
    localparam int unsigned LW = 4;
    localparam int unsigned DW = 4 * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    size = 2'd0;
    logic [DW-1:0] operand = '0;
    logic          x_in = 1'b0;
    logic          z_in = 1'b0;
    logic [DW-1:0] result;
    logic          x_out, n_out, z_out, v_out, c_out, done;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    negx_unit #(.LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .size(size), .operand(operand),
        .x_in(x_in), .z_in(z_in), .result(result), .x_out(x_out), .n_out(n_out),
        .z_out(z_out), .v_out(v_out), .c_out(c_out), .done(done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected values from the arithmetic definition; flags packed {x,n,z,v,c}
    task automatic model(input logic [DW-1:0] op, input logic [1:0] sz, input logic xi,
                         input logic zi, output logic [DW-1:0] res, output logic [4:0] fl);
        int w;
        longint m, d, sop, sres;
        w    = (sz == 2'd0) ? LW : (sz == 2'd1) ? 2*LW : DW;
        m    = (longint'(1) << w) - 1;
        d    = (0 - longint'(op) - longint'(xi)) & m;
        sop  = (longint'(op) >> (w-1)) & 1;
        sres = (d >> (w-1)) & 1;
        res  = DW'((longint'(op) & ~m) | d);
        fl[4] = (sop | sres) != 0;
        fl[3] = sres != 0;
        fl[2] = zi && (d == 0);
        fl[1] = (sop & sres) != 0;
        fl[0] = (sop | sres) != 0;
    endtask

    function automatic logic [4:0] flags_now();
        return {x_out, n_out, z_out, v_out, c_out};
    endfunction

    // one operation followed by an idle cycle; checks R1 R2 R7 result, R3 R4 R5 R6 flags, R8 done
    task automatic run_op(input logic [DW-1:0] op, input logic [1:0] sz, input logic xi, input logic zi);
        logic [DW-1:0] er;
        logic [4:0]    ef;
        model(op, sz, xi, zi, er, ef);
        @(negedge clk);
        operand = op; size = sz; x_in = xi; z_in = zi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(result == er, "R1 R2 R7 result", result, er);
        check(flags_now() == ef, "R3 R4 R5 R6 flags", flags_now(), ef);
        check(done == 1'b1, "R8 done pulse", done, 1);
    endtask

    initial begin
        logic [DW-1:0] er, saved;
        logic [4:0]    ef, fsaved;
        repeat (3) @(negedge clk);
        check(result == '0 && flags_now() == 5'd0 && !done, "R10 reset state", {flags_now(), result}, 0);
        rst = 1'b0;

        // exhaustive one- and two-lane sweeps
        for (int s = 0; s < 2; s++)
            for (int v = 0; v < (1 << ((s + 1) * LW)); v++)
                for (int k = 0; k < 4; k++)
                    run_op(DW'(v) | DW'(16'hA500 & (s == 0 ? 16'hFFF0 : 16'hFF00)),
                           2'(s), k[0], k[1]);

        // full size, strided plus extremes, both the normal and the alternate code
        for (int v = 0; v < (1 << DW); v += 37)
            for (int k = 0; k < 4; k++) run_op(DW'(v), 2'd2, k[0], k[1]);
        run_op(16'h8000, 2'd2, 1'b0, 1'b1);
        run_op(16'h0000, 2'd2, 1'b1, 1'b1);
        run_op(16'hFFFF, 2'd2, 1'b1, 1'b1);
        for (int v = 0; v < (1 << DW); v += 1013)
            for (int k = 0; k < 4; k++) run_op(DW'(v), 2'd3, k[0], k[1]);

        // R8 back-to-back starts
        @(negedge clk);
        operand = 16'h1234; size = 2'd1; x_in = 1'b1; z_in = 1'b1; start = 1'b1;
        @(negedge clk);
        model(16'h1234, 2'd1, 1'b1, 1'b1, er, ef);
        check(result == er && done, "R8 first of pair", result, er);
        operand = 16'h0000; size = 2'd0; x_in = 1'b0; z_in = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model(16'h0000, 2'd0, 1'b0, 1'b1, er, ef);
        check(result == er && flags_now() == ef && done, "R8 second of pair", {flags_now(), result}, {ef, er});

        // R9 idle hold with changing inputs
        saved = result; fsaved = flags_now();
        operand = 16'hBEEF; size = 2'd2; x_in = 1'b1; z_in = 1'b0;
        @(negedge clk);
        check(result == saved && flags_now() == fsaved && !done, "R9 hold", {flags_now(), result}, {fsaved, saved});
        operand = 16'h0001;
        @(negedge clk);
        check(result == saved && flags_now() == fsaved, "R9 hold again", {flags_now(), result}, {fsaved, saved});

        // R10 reset after a nonzero state
        run_op(16'h0081, 2'd0, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(result == '0 && flags_now() == 5'd0 && !done, "R10 reset mid-run", {flags_now(), result}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule